// File: doc/BRIEF.md
# Switch Port Enable and Flush Gate

This block sits between one port of a small packet switch and the DMA engine that serves it. It holds two enable bits for the port: one for the transmit path, which runs from the application into the switch, and one for the receive path, which runs from the switch out to the DMA. Register writes load both bits. A per-port disable pin forces both bits to zero. A global switch-enable input, when low, empties every buffer of the port.

On the transmit path the application writes framed words (data, start, end, valid, ready) into an input frame FIFO. The switch fabric drains that FIFO. Each accepted frame returns a one-cycle status pulse, and the pulse carries an error bit when part of the frame did not fit in the FIFO. While transmit is disabled the writer is never stalled: ready stays high, every word is discarded and no status is produced. On the receive path the fabric pushes framed words into an output frame FIFO, and the DMA reads them out. Clearing the receive enable empties that FIFO at once, so a frame that is only partly delivered stops without its end marker.

Every flush acts on the clock edge that samples the condition that causes it, and the FIFO pointers return to empty on that same edge.

Top module: `swpf_port_gate`

## Requirements
- R1: When `port_dis` is 1 at a clock edge, both `port_tx_en` and `port_rx_en` are 0 after that edge, even when `cfg_wr` requests a 1 in the same cycle.
- R2: After reset both enables are 0. With `port_dis` low, a cycle with `cfg_wr`=1 loads `port_tx_en` from `cfg_tx_en` and `port_rx_en` from `cfg_rx_en` at that edge. Without a write the bits hold their value.
- R3: While `port_tx_en` is 0, `app_ready` is 1 and no word written by the application ever reaches `fab_tx_valid`.
- R4: An edge that leaves the transmit enable at 0 also empties the input FIFO, so `fab_tx_valid` is 0 after it.
- R5: No `txs_valid` pulse follows a word accepted while transmit is disabled, and none follows a frame whose end arrives after the enable was cleared.
- R6: When transmit is enabled, `txs_valid` is 1 for exactly the cycle after the edge that accepts a frame's end word, with `txs_err`=0 when the whole frame was stored.
- R7: With `STALL_ON_FULL`=0, `app_ready` stays 1 when the input FIFO is full. Words that arrive while it is full are dropped, and that frame's status has `txs_err`=1.
- R8: After transmit is enabled, a frame is accepted only from a word with `app_sop`=1. Earlier words without a start marker are dropped and produce no status.
- R9: An edge that leaves the receive enable at 0 empties the output FIFO, so `dma_valid` is 0 after it. A frame that was partly delivered is never completed with `dma_eop`, and fabric words sent while receive is disabled are discarded with `fab_rx_ready`=1.
- R10: A cycle with `switch_en`=0 empties both FIFOs, so `fab_tx_valid` and `dma_valid` are 0 after that edge. The enable bits keep their value.
- R11: Stored words leave in arrival order with their data, start and end flags unchanged: application words on the `fab_tx_*` side, and fabric words on the `dma_*` side whenever `dma_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| switch_en | input | 1 | Global switch enable; low flushes both FIFOs |
| port_dis | input | 1 | Port disable pin; clears both enables |
| cfg_wr | input | 1 | Register write strobe for the enables |
| cfg_tx_en | input | 1 | Transmit enable value written |
| cfg_rx_en | input | 1 | Receive enable value written |
| port_tx_en | output | 1 | Current transmit enable |
| port_rx_en | output | 1 | Current receive enable |
| app_data | input | DATA_W | Application write data |
| app_sop | input | 1 | First word of a frame |
| app_eop | input | 1 | Last word of a frame |
| app_valid | input | 1 | Application word valid |
| app_ready | output | 1 | Block accepts the application word |
| txs_valid | output | 1 | Per-frame transmit status strobe |
| txs_err | output | 1 | Frame overflowed the input FIFO |
| fab_tx_data | output | DATA_W | Head word of the input FIFO |
| fab_tx_sop | output | 1 | Head word starts a frame |
| fab_tx_eop | output | 1 | Head word ends a frame |
| fab_tx_valid | output | 1 | Input FIFO not empty |
| fab_tx_ready | input | 1 | Fabric takes the head word |
| fab_rx_data | input | DATA_W | Fabric word toward the DMA |
| fab_rx_sop | input | 1 | Fabric word starts a frame |
| fab_rx_eop | input | 1 | Fabric word ends a frame |
| fab_rx_valid | input | 1 | Fabric word valid |
| fab_rx_ready | output | 1 | Block accepts the fabric word |
| dma_data | output | DATA_W | Head word of the output FIFO |
| dma_sop | output | 1 | Head word starts a frame |
| dma_eop | output | 1 | Head word ends a frame |
| dma_valid | output | 1 | Output FIFO not empty |
| dma_ready | input | 1 | DMA takes the head word |

## Verification
The bench uses DATA_W=16, TX_DEPTH=8, RX_DEPTH=8 and STALL_ON_FULL=0. With 8-entry FIFOs, a 10-word frame overflows the input FIFO within a few cycles. That overflow shows that ready stays high, which words are dropped and how the error bit in the status is set. In the dropping variant a flushed writer and an overflowing writer both see ready held high, so the checks for R3 and R7 are reached without any back-pressure. Holding the fabric and DMA ready inputs low keeps partial frames parked in each FIFO, so each flush (disable pin, register clear, global switch enable) can be seen emptying a FIFO that is not already empty.

// File: rtl/swpf_pkg.sv
package swpf_pkg;
   typedef struct packed {
      logic sop;
      logic eop;
   } swpf_mark_t;

   localparam int MARK_W = $bits(swpf_mark_t);

   function automatic bit swpf_is_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/swpf_frame_fifo.sv
module swpf_frame_fifo #(
   parameter int WIDTH = 34,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             full,
   output logic             empty
);
   import swpf_pkg::*;

   localparam int AW = $clog2(DEPTH);

   if (!swpf_is_pow2(DEPTH)) begin : g_bad_depth
      $error("swpf_frame_fifo: DEPTH must be a power of two >= 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("swpf_frame_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [AW:0]      cnt;
   logic             do_wr, do_rd;

   assign full  = (cnt == (AW+1)'(DEPTH));
   assign empty = (cnt == '0);
   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && !empty;
   assign rd_data = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr && !clr) mem[wptr] <= wr_data;
   end

   // R4 / R9 / R10: a clear leaves the FIFO empty on the next cycle
   assert_clr_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);
   assert_no_overfill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en && !clr) |=> full);
endmodule

// File: rtl/swpf_enable_ctrl.sv
module swpf_enable_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic switch_en,
   input  logic port_dis,
   input  logic cfg_wr,
   input  logic cfg_tx_en,
   input  logic cfg_rx_en,
   output logic tx_en,
   output logic rx_en,
   output logic tx_flush,
   output logic rx_flush
);
   logic tx_nxt, rx_nxt;

   always_comb begin
      tx_nxt = tx_en;
      rx_nxt = rx_en;
      if (port_dis) begin
         tx_nxt = 1'b0;
         rx_nxt = 1'b0;
      end else if (cfg_wr) begin
         tx_nxt = cfg_tx_en;
         rx_nxt = cfg_rx_en;
      end
   end

   assign tx_flush = !tx_nxt || !switch_en;
   assign rx_flush = !rx_nxt || !switch_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en <= 1'b0;
         rx_en <= 1'b0;
      end else begin
         tx_en <= tx_nxt;
         rx_en <= rx_nxt;
      end
   end

   assert_dis_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      port_dis |=> (!tx_en && !rx_en));
   assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_dis && !cfg_wr) |=> ($stable(tx_en) && $stable(rx_en)));
endmodule

// File: rtl/swpf_tx_ingress.sv
module swpf_tx_ingress #(
   parameter bit STALL_ON_FULL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic tx_flush,
   input  logic app_sop,
   input  logic app_eop,
   input  logic app_valid,
   output logic app_ready,
   input  logic buf_full,
   output logic buf_wr,
   output logic txs_valid,
   output logic txs_err
);
   logic in_frame;
   logic err_acc;
   logic take;
   logic lost;

   if (STALL_ON_FULL) begin : g_stall
      assign app_ready = !tx_en || !buf_full;
   end else begin : g_drop
      assign app_ready = 1'b1;
   end

   assign take   = app_valid && app_ready && tx_en && !tx_flush && (app_sop || in_frame);
   assign lost   = take && buf_full;
   assign buf_wr = take && !buf_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame  <= 1'b0;
         err_acc   <= 1'b0;
         txs_valid <= 1'b0;
         txs_err   <= 1'b0;
      end else if (tx_flush) begin
         in_frame  <= 1'b0;
         err_acc   <= 1'b0;
         txs_valid <= 1'b0;
         txs_err   <= 1'b0;
      end else begin
         txs_valid <= take && app_eop;
         txs_err   <= take && app_eop && (lost || (err_acc && !app_sop));
         if (take) begin
            in_frame <= !app_eop;
            err_acc  <= app_eop ? 1'b0 : (lost || (err_acc && !app_sop));
         end
      end
   end

   assert_no_status_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> !txs_valid);
   assert_status_after_eop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      txs_valid |-> $past(app_valid && app_eop && tx_en));
endmodule

// File: rtl/swpf_port_gate.sv
module swpf_port_gate #(
   parameter int DATA_W        = 32,
   parameter int TX_DEPTH      = 8,
   parameter int RX_DEPTH      = 8,
   parameter bit STALL_ON_FULL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              switch_en,
   input  logic              port_dis,
   input  logic              cfg_wr,
   input  logic              cfg_tx_en,
   input  logic              cfg_rx_en,
   output logic              port_tx_en,
   output logic              port_rx_en,
   input  logic [DATA_W-1:0] app_data,
   input  logic              app_sop,
   input  logic              app_eop,
   input  logic              app_valid,
   output logic              app_ready,
   output logic              txs_valid,
   output logic              txs_err,
   output logic [DATA_W-1:0] fab_tx_data,
   output logic              fab_tx_sop,
   output logic              fab_tx_eop,
   output logic              fab_tx_valid,
   input  logic              fab_tx_ready,
   input  logic [DATA_W-1:0] fab_rx_data,
   input  logic              fab_rx_sop,
   input  logic              fab_rx_eop,
   input  logic              fab_rx_valid,
   output logic              fab_rx_ready,
   output logic [DATA_W-1:0] dma_data,
   output logic              dma_sop,
   output logic              dma_eop,
   output logic              dma_valid,
   input  logic              dma_ready
);
   import swpf_pkg::*;

   localparam int WORD_W = DATA_W + MARK_W;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("swpf_port_gate: DATA_W must be positive");
   end

   logic tx_flush, rx_flush;
   logic tx_full, tx_empty, tx_wr;
   logic rx_full, rx_empty, rx_wr;
   logic [WORD_W-1:0] tx_in, tx_out, rx_in, rx_out;
   swpf_mark_t tx_mark_in, rx_mark_in, tx_mark_out, rx_mark_out;

   swpf_enable_ctrl u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .switch_en (switch_en),
      .port_dis  (port_dis),
      .cfg_wr    (cfg_wr),
      .cfg_tx_en (cfg_tx_en),
      .cfg_rx_en (cfg_rx_en),
      .tx_en     (port_tx_en),
      .rx_en     (port_rx_en),
      .tx_flush  (tx_flush),
      .rx_flush  (rx_flush)
   );

   swpf_tx_ingress #(.STALL_ON_FULL(STALL_ON_FULL)) u_ing (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (port_tx_en),
      .tx_flush  (tx_flush),
      .app_sop   (app_sop),
      .app_eop   (app_eop),
      .app_valid (app_valid),
      .app_ready (app_ready),
      .buf_full  (tx_full),
      .buf_wr    (tx_wr),
      .txs_valid (txs_valid),
      .txs_err   (txs_err)
   );

   assign tx_mark_in = '{sop: app_sop, eop: app_eop};
   assign tx_in      = {tx_mark_in, app_data};

   swpf_frame_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (tx_flush),
      .wr_en   (tx_wr),
      .wr_data (tx_in),
      .rd_en   (fab_tx_ready),
      .rd_data (tx_out),
      .full    (tx_full),
      .empty   (tx_empty)
   );

   assign tx_mark_out  = swpf_mark_t'(tx_out[WORD_W-1:DATA_W]);
   assign fab_tx_data  = tx_out[DATA_W-1:0];
   assign fab_tx_sop   = tx_mark_out.sop;
   assign fab_tx_eop   = tx_mark_out.eop;
   assign fab_tx_valid = !tx_empty;

   // receive path: words are discarded with ready high while disabled
   assign fab_rx_ready = port_rx_en ? !rx_full : 1'b1;
   assign rx_wr        = fab_rx_valid && port_rx_en && !rx_flush && !rx_full;
   assign rx_mark_in   = '{sop: fab_rx_sop, eop: fab_rx_eop};
   assign rx_in        = {rx_mark_in, fab_rx_data};

   swpf_frame_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (rx_flush),
      .wr_en   (rx_wr),
      .wr_data (rx_in),
      .rd_en   (dma_ready),
      .rd_data (rx_out),
      .full    (rx_full),
      .empty   (rx_empty)
   );

   assign rx_mark_out = swpf_mark_t'(rx_out[WORD_W-1:DATA_W]);
   assign dma_data    = rx_out[DATA_W-1:0];
   assign dma_sop     = rx_mark_out.sop;
   assign dma_eop     = rx_mark_out.eop;
   assign dma_valid   = !rx_empty;

   assert_switch_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !switch_en |=> (!dma_valid && !fab_tx_valid));
   assert_dis_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      port_dis |=> !dma_valid);
   assert_ready_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !port_tx_en |=> (!fab_tx_valid || port_tx_en));
endmodule

// File: tb/swpf_port_gate_tb.sv
module swpf_port_gate_tb;
   localparam int  DW      = 16;
   localparam int  DEPTH   = 8;
   localparam time CLK_PER = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic switch_en, port_dis, cfg_wr, cfg_tx_en, cfg_rx_en;
   logic port_tx_en, port_rx_en;
   logic [DW-1:0] app_data;
   logic app_sop, app_eop, app_valid, app_ready, txs_valid, txs_err;
   logic [DW-1:0] fab_tx_data;
   logic fab_tx_sop, fab_tx_eop, fab_tx_valid, fab_tx_ready;
   logic [DW-1:0] fab_rx_data;
   logic fab_rx_sop, fab_rx_eop, fab_rx_valid, fab_rx_ready;
   logic [DW-1:0] dma_data;
   logic dma_sop, dma_eop, dma_valid, dma_ready;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;
   logic [DW+1:0] exp_tx[$];
   logic [DW+1:0] exp_rx[$];
   bit exp_st[$];

   always #(CLK_PER/2) clk = ~clk;

   swpf_port_gate #(.DATA_W(DW), .TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH), .STALL_ON_FULL(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .switch_en(switch_en), .port_dis(port_dis),
      .cfg_wr(cfg_wr), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
      .port_tx_en(port_tx_en), .port_rx_en(port_rx_en),
      .app_data(app_data), .app_sop(app_sop), .app_eop(app_eop),
      .app_valid(app_valid), .app_ready(app_ready),
      .txs_valid(txs_valid), .txs_err(txs_err),
      .fab_tx_data(fab_tx_data), .fab_tx_sop(fab_tx_sop), .fab_tx_eop(fab_tx_eop),
      .fab_tx_valid(fab_tx_valid), .fab_tx_ready(fab_tx_ready),
      .fab_rx_data(fab_rx_data), .fab_rx_sop(fab_rx_sop), .fab_rx_eop(fab_rx_eop),
      .fab_rx_valid(fab_rx_valid), .fab_rx_ready(fab_rx_ready),
      .dma_data(dma_data), .dma_sop(dma_sop), .dma_eop(dma_eop),
      .dma_valid(dma_valid), .dma_ready(dma_ready)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   endtask

   // monitor: pops scoreboard entries as the design produces results
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (fab_tx_valid && fab_tx_ready) begin
            if (exp_tx.size() == 0)
               chk(1'b0, "R11 tx unexpected word", {14'd0, fab_tx_sop, fab_tx_eop, fab_tx_data}, 32'hFFFF_FFFF);
            else begin
               logic [DW+1:0] e;
               e = exp_tx.pop_front();
               chk({fab_tx_sop, fab_tx_eop, fab_tx_data} == e, "R11 tx word",
                   {14'd0, fab_tx_sop, fab_tx_eop, fab_tx_data}, {14'd0, e});
            end
         end
         if (dma_valid && dma_ready) begin
            if (exp_rx.size() == 0)
               chk(1'b0, "R9 rx unexpected word", {14'd0, dma_sop, dma_eop, dma_data}, 32'hFFFF_FFFF);
            else begin
               logic [DW+1:0] e;
               e = exp_rx.pop_front();
               chk({dma_sop, dma_eop, dma_data} == e, "R11 rx word",
                   {14'd0, dma_sop, dma_eop, dma_data}, {14'd0, e});
            end
         end
         if (txs_valid) begin
            if (exp_st.size() == 0)
               chk(1'b0, "R5 unexpected status", {31'd0, txs_err}, 32'hFFFF_FFFF);
            else begin
               bit e;
               e = exp_st.pop_front();
               chk(txs_err == e, "R6 R7 status err", {31'd0, txs_err}, {31'd0, e});
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      finish_run();
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic put_word(input logic [DW-1:0] d, input logic s, input logic e);
      app_data = d; app_sop = s; app_eop = e; app_valid = 1'b1;
      tick();
      app_valid = 1'b0; app_sop = 1'b0; app_eop = 1'b0;
   endtask

   task automatic put_rx(input logic [DW-1:0] d, input logic s, input logic e, input bit push);
      if (push) exp_rx.push_back({s, e, d});
      fab_rx_data = d; fab_rx_sop = s; fab_rx_eop = e; fab_rx_valid = 1'b1;
      tick();
      fab_rx_valid = 1'b0; fab_rx_sop = 1'b0; fab_rx_eop = 1'b0;
   endtask

   // driver: pushes the expected words and status, then drives the frame
   task automatic send_frame(input int n, input logic [DW-1:0] base, input bit push_w,
                             input bit push_st, input bit err, input int keep);
      for (int i = 0; i < n; i++) begin
         logic s, e;
         s = (i == 0);
         e = (i == n - 1);
         if (push_w && i < keep) exp_tx.push_back({s, e, base + DW'(i)});
         if (push_st && e) exp_st.push_back(err);
         put_word(base + DW'(i), s, e);
      end
   endtask

   task automatic set_en(input logic tx, input logic rx, input logic dis);
      cfg_wr = 1'b1; cfg_tx_en = tx; cfg_rx_en = rx; port_dis = dis;
      tick();
      cfg_wr = 1'b0; port_dis = 1'b0;
   endtask

   task automatic drain_check(input string tag);
      repeat (DEPTH + 4) tick();
      chk(exp_tx.size() == 0, tag, exp_tx.size(), 0);
      chk(exp_rx.size() == 0, tag, exp_rx.size(), 0);
      chk(exp_st.size() == 0, tag, exp_st.size(), 0);
   endtask

   initial begin
      switch_en = 1'b1; port_dis = 1'b0; cfg_wr = 1'b0; cfg_tx_en = 1'b0; cfg_rx_en = 1'b0;
      app_data = '0; app_sop = 1'b0; app_eop = 1'b0; app_valid = 1'b0;
      fab_tx_ready = 1'b1; dma_ready = 1'b1;
      fab_rx_data = '0; fab_rx_sop = 1'b0; fab_rx_eop = 1'b0; fab_rx_valid = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(port_tx_en == 1'b0 && port_rx_en == 1'b0, "R2 reset enables", {port_tx_en, port_rx_en}, 0);
      chk(app_ready == 1'b1, "R3 ready while off", app_ready, 1);
      chk(!fab_tx_valid && !dma_valid && !txs_valid, "R2 reset outputs",
          {fab_tx_valid, dma_valid, txs_valid}, 0);

      // R3 / R5: a whole frame written while transmit is off vanishes
      tick();
      put_word(16'hA0, 1'b1, 1'b1);
      @(negedge clk);
      chk(!fab_tx_valid, "R3 discarded word", fab_tx_valid, 0);
      chk(!txs_valid, "R5 no status while off", txs_valid, 0);

      // R1: disable pin beats a same-cycle write
      tick();
      set_en(1'b1, 1'b1, 1'b1);
      @(negedge clk);
      chk(!port_tx_en && !port_rx_en, "R1 dis priority", {port_tx_en, port_rx_en}, 0);
      tick();
      set_en(1'b1, 1'b1, 1'b0);
      @(negedge clk);
      chk(port_tx_en && port_rx_en, "R2 write sets", {port_tx_en, port_rx_en}, 3);

      // R6 / R11: normal frames, including a single-word frame
      tick();
      send_frame(4, 16'h100, 1, 1, 0, 99);
      send_frame(1, 16'h200, 1, 1, 0, 99);
      send_frame(3, 16'h300, 1, 1, 0, 99);
      drain_check("R6 R11 normal frames");

      // R8: words before a start marker are dropped
      put_word(16'h400, 1'b0, 1'b0);
      put_word(16'h401, 1'b0, 1'b1);
      send_frame(2, 16'h410, 1, 1, 0, 99);
      drain_check("R8 wait for sop");

      // R7: overflow of the input FIFO
      fab_tx_ready = 1'b0;
      send_frame(10, 16'h500, 1, 1, 1, DEPTH);
      @(negedge clk);
      chk(app_ready == 1'b1, "R7 ready while full", app_ready, 1);
      tick();
      fab_tx_ready = 1'b1;
      drain_check("R7 overflow");

      // R4 / R5: clear transmit with stored words and a frame in progress
      fab_tx_ready = 1'b0;
      send_frame(2, 16'h600, 0, 1, 0, 0);
      put_word(16'h610, 1'b1, 1'b0);
      put_word(16'h611, 1'b0, 1'b0);
      @(negedge clk);
      chk(fab_tx_valid, "R4 words parked", fab_tx_valid, 1);
      tick();
      set_en(1'b0, 1'b1, 1'b0);
      @(negedge clk);
      chk(!fab_tx_valid, "R4 flush on clear", fab_tx_valid, 0);
      chk(app_ready, "R3 ready after clear", app_ready, 1);
      tick();
      put_word(16'h612, 1'b0, 1'b1);
      put_word(16'h620, 1'b1, 1'b1);
      @(negedge clk);
      chk(!fab_tx_valid && !txs_valid, "R5 no status after clear", {fab_tx_valid, txs_valid}, 0);
      tick();
      fab_tx_ready = 1'b1;
      set_en(1'b1, 1'b1, 1'b0);
      drain_check("R5 after clear");

      // R9: disable pin aborts a partly delivered frame
      dma_ready = 1'b0;
      put_rx(16'h700, 1'b1, 1'b0, 0);
      put_rx(16'h701, 1'b0, 1'b0, 0);
      @(negedge clk);
      chk(dma_valid && dma_sop, "R11 rx head", {dma_valid, dma_sop}, 3);
      tick();
      port_dis = 1'b1;
      tick();
      port_dis = 1'b0;
      @(negedge clk);
      chk(!dma_valid, "R9 abort", dma_valid, 0);
      chk(!port_rx_en && !port_tx_en, "R1 pin clears", {port_tx_en, port_rx_en}, 0);
      tick();
      dma_ready = 1'b1;
      put_rx(16'h702, 1'b0, 1'b1, 0);
      @(negedge clk);
      chk(!dma_valid && fab_rx_ready, "R9 discard while off", {dma_valid, fab_rx_ready}, 1);
      tick();
      set_en(1'b1, 1'b1, 1'b0);
      put_rx(16'h710, 1'b1, 1'b0, 1);
      put_rx(16'h711, 1'b0, 1'b0, 1);
      put_rx(16'h712, 1'b0, 1'b1, 1);
      drain_check("R9 R11 rx after re-enable");

      // R10: global switch enable low flushes both sides
      fab_tx_ready = 1'b0; dma_ready = 1'b0;
      send_frame(2, 16'h800, 0, 1, 0, 0);
      put_rx(16'h810, 1'b1, 1'b1, 0);
      @(negedge clk);
      chk(fab_tx_valid && dma_valid, "R10 parked", {fab_tx_valid, dma_valid}, 3);
      tick();
      switch_en = 1'b0;
      tick();
      switch_en = 1'b1;
      @(negedge clk);
      chk(!fab_tx_valid && !dma_valid, "R10 flush", {fab_tx_valid, dma_valid}, 0);
      chk(port_tx_en && port_rx_en, "R10 enables kept", {port_tx_en, port_rx_en}, 3);
      tick();
      fab_tx_ready = 1'b1; dma_ready = 1'b1;
      send_frame(3, 16'h900, 1, 1, 0, 99);
      put_rx(16'h910, 1'b1, 1'b1, 1);
      drain_check("R10 R11 after switch flush");

      finish_run();
   end
endmodule